// File: doc/BRIEF.md
# Descriptor-Chained Frame Fetch DMA

This block supplies a display controller with frame data by walking a linked list of four-word descriptors held in memory. Software writes the byte address of the first descriptor. The block reads that descriptor as one four-word burst. It then reads the number of 32-bit words named in the descriptor's command word, starting at the descriptor's source address, and moves on to the descriptor that the link word names. Because a descriptor may link to itself, or two descriptors may link to each other, the chain runs forever without software help. A single frame buffer can repeat every frame, or a palette load can alternate with a frame fetch.

One command bit steers a descriptor's words to a palette RAM write port instead of the pixel FIFO. Data reads use bursts of up to 16 words. A pixel burst is only requested when the FIFO has room for all of it, so the memory side never has to be stalled. The display side pulls one word per cycle. If it pulls from an empty FIFO, a sticky underrun flag is raised. The output either holds its last word (protection on) or drives zero (protection off).

Top module: `frame_fetch_dma`

## Requirements
- R1: A descriptor is read as a single request of burst length 4 at the descriptor address. The returned words, in order, are the link address (offset 0), source address (offset 4), frame tag (offset 8) and command (offset 12). The two low bits of every descriptor, link and source address are forced to zero.
- R2: Command bits 23:0 give the transfer length in 32-bit words. When command bit 28 is 1, the words are written to the palette port, with the index starting at 0 and incrementing by one per word. Otherwise they enter the pixel FIFO in order.
- R3: Data is read from consecutive word addresses starting at the source address. Each request asks for min(16, words remaining) words.
- R4: After the last word of a descriptor, the next descriptor is fetched from its link address, so self-linked and mutually linked chains repeat indefinitely.
- R5: A descriptor with length 0 issues no data request, and the block goes straight on to its link.
- R6: A start write while idle begins a fetch at that address. A start write while running is held and replaces the link of the descriptor in progress once that descriptor's data is complete.
- R7: A pixel burst is requested only when the FIFO's free space is at least the burst length. Palette bursts are never held back by the FIFO.
- R8: `frame_id_o` takes a descriptor's frame tag when the descriptor is read, before any of its data is moved.
- R9: When `pix_ready_i` is high and the FIFO holds data, `pix_valid_o` is high in the next cycle with the oldest FIFO word on `pix_data_o`.
- R10: When `pix_ready_i` is high and the FIFO is empty, `pix_valid_o` is low in the next cycle and `underrun_o` becomes 1 and stays 1. `pix_data_o` keeps its value if `protect_i` is 1, and becomes 0 if `protect_i` is 0.
- R11: `underrun_clr_i` clears `underrun_o`. A new underrun in the same cycle wins, and the flag stays set.
- R12: After reset, `mem_req_o`, `pal_we_o`, `pix_valid_o` and `underrun_o` are 0, `frame_id_o` and `pix_data_o` are 0, and the block is idle until a start write.
- R13: While `mem_req_o` is high and `mem_gnt_i` is low, the request stays high with `mem_addr_o` and `mem_burst_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_wr_i | input | 1 | Write strobe for the first-descriptor address |
| start_addr_i | input | 32 | First-descriptor byte address |
| mem_req_o | output | 1 | Read request valid |
| mem_addr_o | output | 32 | Byte address of the first word of the burst |
| mem_burst_o | output | 5 | Burst length in words (1 to 16) |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read word valid |
| mem_rdata_i | input | 32 | Read word |
| pal_we_o | output | 1 | Palette RAM write enable |
| pal_addr_o | output | 8 | Palette RAM index |
| pal_wdata_o | output | 32 | Palette RAM write data |
| pix_ready_i | input | 1 | Display pulls one word this cycle |
| pix_valid_o | output | 1 | A new word is on pix_data_o |
| pix_data_o | output | 32 | Pixel word |
| protect_i | input | 1 | Hold last word on underrun |
| underrun_clr_i | input | 1 | Clear the underrun flag |
| underrun_o | output | 1 | Sticky underrun flag |
| frame_id_o | output | 32 | Frame tag of the latest descriptor |

## Verification
The underrun flag's set and clear can land in the same cycle. This is provoked by driving `pix_ready_i` with an empty FIFO while `underrun_clr_i` is pulsed, and the flag is judged to stay set. Clear alone, with the display idle, is judged to drop it. The pending start and a descriptor's completion also meet. The bench writes a new chain start while a self-linked descriptor is on its third pass, and expects exactly three full passes followed by the new chain in the pixel and palette streams.

// File: rtl/fdma_pkg.sv
// Package: shared constants and state encoding for the frame fetch DMA.
// Assumes 32-bit descriptor words; the length field and palette bit position
// are fixed by the descriptor format that software writes.
package fdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_REQ,
        ST_DESC_RX,
        ST_XFER_REQ,
        ST_XFER_RX,
        ST_ADVANCE
    } fdma_state_e;

    localparam int DESC_WORDS  = 4;
    localparam int CMD_LEN_W   = 24;
    localparam int CMD_PAL_BIT = 28;

    localparam logic [1:0] DW_LINK = 2'd0;
    localparam logic [1:0] DW_SRC  = 2'd1;
    localparam logic [1:0] DW_TAG  = 2'd2;

endpackage

// File: rtl/fdma_fifo.sv
// Module: pixel word FIFO between the fetch sequencer and the output stage.
// Assumes the writer never writes when full (the sequencer checks free space
// before each burst). Head word is visible combinationally.
module fdma_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rd_i,
    output logic [DW-1:0] head_o,
    output logic          empty_o,
    output logic [CW-1:0] free_o
);

    logic [DW-1:0] store_q [DEPTH];
    logic [PW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] used_q;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_i) store_q[wptr_q] <= wdata_i;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            used_q <= '0;
        end else begin
            if (wr_i) wptr_q <= (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + PW'(1);
            if (rd_i) rptr_q <= (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + PW'(1);
            used_q <= used_q + CW'(wr_i) - CW'(rd_i);
        end
    end

    assign head_o  = store_q[rptr_q];
    assign empty_o = (used_q == '0);
    assign free_o  = CW'(DEPTH) - used_q;

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> (free_o != '0));

    assert_no_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |-> !empty_o);

endmodule

// File: rtl/fdma_outstage.sv
// Module: display-side output register with underrun protection.
// Pops one FIFO word per pull; on a pull from an empty FIFO it raises a
// sticky flag and either holds or zeroes the output word.
module fdma_outstage #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pull_i,
    input  logic          protect_i,
    input  logic          clr_i,
    input  logic          fifo_empty_i,
    input  logic [DW-1:0] fifo_head_i,
    output logic          fifo_rd_o,
    output logic          pix_valid_o,
    output logic [DW-1:0] pix_data_o,
    output logic          underrun_o
);

    assign fifo_rd_o = pull_i && !fifo_empty_i;

    // Strobe marking a freshly popped word.
    always_ff @(posedge clk) begin
        if (!rst_n) pix_valid_o <= 1'b0;
        else        pix_valid_o <= fifo_rd_o;
    end

    // Output word: new data, zero on unprotected underrun, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pix_data_o <= '0;
        else if (fifo_rd_o)              pix_data_o <= fifo_head_i;
        else if (pull_i && !protect_i)   pix_data_o <= '0;
    end

    // Sticky underrun flag; a new underrun beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                        underrun_o <= 1'b0;
        else if (pull_i && fifo_empty_i)   underrun_o <= 1'b1;
        else if (clr_i)                    underrun_o <= 1'b0;
    end

    assert_underrun_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_i && fifo_empty_i) |=> underrun_o);

    assert_hold_on_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_i && fifo_empty_i && protect_i) |=> ($stable(pix_data_o) && !pix_valid_o));

    assert_pop_gives_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_i && !fifo_empty_i) |=> pix_valid_o);

endmodule

// File: rtl/fdma_seq.sv
// Module: descriptor walker and burst sequencer.
// Reads four-word descriptors, then moves the data in bursts of at most
// BURST words to the FIFO or the palette port. Assumes one outstanding
// request at a time and that responses arrive in order.
module fdma_seq
    import fdma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int BURST      = 16,
    parameter int FIFO_DEPTH = 32,
    parameter int PAL_AW     = 8,
    localparam int BLW       = $clog2(BURST + 1),
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr_i,
    input  logic [AW-1:0]     start_addr_i,
    output logic              mem_req_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [BLW-1:0]    mem_burst_o,
    input  logic              mem_gnt_i,
    input  logic              mem_rvalid_i,
    input  logic [DW-1:0]     mem_rdata_i,
    input  logic [CW-1:0]     fifo_free_i,
    output logic              fifo_wr_o,
    output logic [DW-1:0]     fifo_wdata_o,
    output logic              pal_we_o,
    output logic [PAL_AW-1:0] pal_addr_o,
    output logic [DW-1:0]     pal_wdata_o,
    output logic [DW-1:0]     frame_id_o
);

    fdma_state_e            state_q;
    logic [AW-1:0]          desc_addr_q, link_q, src_q, pend_addr_q;
    logic                   pend_v_q, pal_q;
    logic [CMD_LEN_W-1:0]   remain_q;
    logic [BLW-1:0]         wcnt_q, blen_q, next_blen;
    logic [PAL_AW-1:0]      pal_idx_q;
    logic                   room_ok, rx_data;

    function automatic logic [AW-1:0] word_align(input logic [AW-1:0] a);
        return {a[AW-1:2], 2'b00};
    endfunction

    // Length of the next data burst.
    assign next_blen = (remain_q > CMD_LEN_W'(BURST)) ? BLW'(BURST) : BLW'(remain_q);
    // Pixel bursts wait for FIFO room; palette bursts never do.
    assign room_ok   = pal_q || (int'(fifo_free_i) >= int'(next_blen));
    assign rx_data   = (state_q == ST_XFER_RX) && mem_rvalid_i;

    // Request port drive.
    always_comb begin
        mem_req_o   = (state_q == ST_DESC_REQ) || ((state_q == ST_XFER_REQ) && room_ok);
        mem_addr_o  = (state_q == ST_DESC_REQ) ? desc_addr_q : src_q;
        mem_burst_o = (state_q == ST_DESC_REQ) ? BLW'(DESC_WORDS) : next_blen;
    end

    assign fifo_wr_o    = rx_data && !pal_q;
    assign fifo_wdata_o = mem_rdata_i;
    assign pal_we_o     = rx_data && pal_q;
    assign pal_addr_o   = pal_idx_q;
    assign pal_wdata_o  = mem_rdata_i;
    assign frame_id_o   = frame_tag_q;

    logic [DW-1:0] frame_tag_q;

    // Main sequencer: descriptor parse, burst steps, chaining.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            desc_addr_q <= '0;
            link_q      <= '0;
            src_q       <= '0;
            pend_addr_q <= '0;
            pend_v_q    <= 1'b0;
            pal_q       <= 1'b0;
            remain_q    <= '0;
            wcnt_q      <= '0;
            blen_q      <= '0;
            pal_idx_q   <= '0;
            frame_tag_q <= '0;
        end else begin
            if (start_wr_i && (state_q != ST_IDLE) && (state_q != ST_ADVANCE)) begin
                pend_v_q    <= 1'b1;
                pend_addr_q <= word_align(start_addr_i);
            end
            case (state_q)
                ST_IDLE: begin
                    if (start_wr_i) begin
                        desc_addr_q <= word_align(start_addr_i);
                        state_q     <= ST_DESC_REQ;
                    end
                end
                ST_DESC_REQ: begin
                    if (mem_gnt_i) begin
                        wcnt_q  <= '0;
                        state_q <= ST_DESC_RX;
                    end
                end
                ST_DESC_RX: begin
                    if (mem_rvalid_i) begin
                        wcnt_q <= wcnt_q + BLW'(1);
                        case (wcnt_q[1:0])
                            DW_LINK: link_q      <= word_align(AW'(mem_rdata_i));
                            DW_SRC:  src_q       <= word_align(AW'(mem_rdata_i));
                            DW_TAG:  frame_tag_q <= mem_rdata_i;
                            default: begin
                                remain_q  <= mem_rdata_i[CMD_LEN_W-1:0];
                                pal_q     <= mem_rdata_i[CMD_PAL_BIT];
                                pal_idx_q <= '0;
                                state_q   <= (mem_rdata_i[CMD_LEN_W-1:0] == '0) ?
                                             ST_ADVANCE : ST_XFER_REQ;
                            end
                        endcase
                    end
                end
                ST_XFER_REQ: begin
                    if (mem_req_o && mem_gnt_i) begin
                        blen_q  <= next_blen;
                        wcnt_q  <= '0;
                        state_q <= ST_XFER_RX;
                    end
                end
                ST_XFER_RX: begin
                    if (mem_rvalid_i) begin
                        src_q    <= src_q + AW'(4);
                        remain_q <= remain_q - CMD_LEN_W'(1);
                        wcnt_q   <= wcnt_q + BLW'(1);
                        if (pal_q) pal_idx_q <= pal_idx_q + PAL_AW'(1);
                        if (wcnt_q == blen_q - BLW'(1))
                            state_q <= (remain_q == CMD_LEN_W'(1)) ? ST_ADVANCE : ST_XFER_REQ;
                    end
                end
                ST_ADVANCE: begin
                    if (start_wr_i)    desc_addr_q <= word_align(start_addr_i);
                    else if (pend_v_q) desc_addr_q <= pend_addr_q;
                    else               desc_addr_q <= link_q;
                    pend_v_q <= 1'b0;
                    state_q  <= ST_DESC_REQ;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_req_held_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_burst_o)));

    assert_burst_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> ((mem_burst_o != '0) && (int'(mem_burst_o) <= BURST)));

    assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

    assert_data_after_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr_o || pal_we_o) |=> $stable(frame_id_o));

endmodule

// File: rtl/frame_fetch_dma.sv
// Module: top of the descriptor-chained frame fetch DMA.
// Connects the sequencer, the pixel FIFO and the display output stage.
// Assumes a memory that accepts one request at a time and returns words in order.
module frame_fetch_dma #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int BURST      = 16,
    parameter int FIFO_DEPTH = 32,
    parameter int PAL_AW     = 8,
    localparam int BLW       = $clog2(BURST + 1),
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr_i,
    input  logic [AW-1:0]     start_addr_i,
    output logic              mem_req_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [BLW-1:0]    mem_burst_o,
    input  logic              mem_gnt_i,
    input  logic              mem_rvalid_i,
    input  logic [DW-1:0]     mem_rdata_i,
    output logic              pal_we_o,
    output logic [PAL_AW-1:0] pal_addr_o,
    output logic [DW-1:0]     pal_wdata_o,
    input  logic              pix_ready_i,
    output logic              pix_valid_o,
    output logic [DW-1:0]     pix_data_o,
    input  logic              protect_i,
    input  logic              underrun_clr_i,
    output logic              underrun_o,
    output logic [DW-1:0]     frame_id_o
);

    logic          fifo_wr, fifo_rd, fifo_empty;
    logic [DW-1:0] fifo_wdata, fifo_head;
    logic [CW-1:0] fifo_free;

    fdma_seq #(
        .AW(AW), .DW(DW), .BURST(BURST), .FIFO_DEPTH(FIFO_DEPTH), .PAL_AW(PAL_AW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_wr_i(start_wr_i), .start_addr_i(start_addr_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_burst_o(mem_burst_o),
        .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .fifo_free_i(fifo_free), .fifo_wr_o(fifo_wr), .fifo_wdata_o(fifo_wdata),
        .pal_we_o(pal_we_o), .pal_addr_o(pal_addr_o), .pal_wdata_o(pal_wdata_o),
        .frame_id_o(frame_id_o)
    );

    fdma_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_i(fifo_wr), .wdata_i(fifo_wdata), .rd_i(fifo_rd),
        .head_o(fifo_head), .empty_o(fifo_empty), .free_o(fifo_free)
    );

    fdma_outstage #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n),
        .pull_i(pix_ready_i), .protect_i(protect_i), .clr_i(underrun_clr_i),
        .fifo_empty_i(fifo_empty), .fifo_head_i(fifo_head), .fifo_rd_o(fifo_rd),
        .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o), .underrun_o(underrun_o)
    );

endmodule

// File: tb/frame_fetch_dma_tb.sv
module frame_fetch_dma_tb;

    localparam int CLK_PERIOD = 10;
    localparam int FDEPTH     = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_wr_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic [4:0]  mem_burst_o;
    logic        mem_gnt_i = 1'b0;
    logic        mem_rvalid_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        pal_we_o;
    logic [7:0]  pal_addr_o;
    logic [31:0] pal_wdata_o;
    logic        pix_ready_i = 1'b0;
    logic        pix_valid_o;
    logic [31:0] pix_data_o;
    logic        protect_i = 1'b1;
    logic        underrun_clr_i = 1'b0;
    logic        underrun_o;
    logic [31:0] frame_id_o;

    frame_fetch_dma u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit sb_on = 1'b0;
    bit done = 1'b0;

    logic [31:0] mem_arr [0:511];
    logic [31:0] qpix [$];
    logic [39:0] qpal [$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic bit is_pix(input logic [31:0] a);
        return (a >= 32'h400) && ((a < 32'h600) || (a >= 32'h700));
    endfunction

    function automatic int region_end(input logic [31:0] a);
        if (a < 32'h600) return 32'h4A0;
        if (a < 32'h700) return 32'h620;
        if (a < 32'h7C0) return 32'h750;
        return 32'h7C0;
    endfunction

    // Memory model: waits two cycles before grant, answers after two cycles.
    int delivered = 0, popped = 0, a_fetch = 0;
    int lat = 0, cnt = 0, wait_n = 0;
    bit busy = 1'b0;
    logic [31:0] baddr, saved_a;
    logic [4:0]  blen, saved_b;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_gnt_i = 1'b0; mem_rvalid_i = 1'b0; busy = 1'b0; wait_n = 0;
        end else if (mem_gnt_i) begin
            mem_gnt_i = 1'b0; busy = 1'b1; lat = 2; cnt = 0; wait_n = 0;
        end else if (busy) begin
            if (lat > 0) begin
                lat--; mem_rvalid_i = 1'b0;
            end else if (cnt == int'(blen)) begin
                mem_rvalid_i = 1'b0; busy = 1'b0;
            end else begin
                mem_rvalid_i = 1'b1;
                mem_rdata_i = mem_arr[int'(baddr >> 2) + cnt];
                if (is_pix(baddr)) delivered++;
                cnt++;
            end
        end else if (mem_req_o) begin
            if (wait_n == 0) begin
                saved_a = mem_addr_o; saved_b = mem_burst_o;
            end else begin
                // R13: request held stable while waiting for grant
                chk(mem_addr_o == saved_a && mem_burst_o == saved_b, "R13", mem_addr_o, saved_a);
            end
            if (wait_n < 2) wait_n++;
            else begin
                if (mem_addr_o < 32'h400) begin
                    chk(mem_burst_o == 5'd4, "R1 descriptor burst", 32'(mem_burst_o), 32'd4);
                    chk(mem_addr_o == 32'h100 || mem_addr_o == 32'h280 || mem_addr_o == 32'h200 ||
                        mem_addr_o == 32'h180, "R1/R4 descriptor address", mem_addr_o, 32'h100);
                end else begin
                    chk(mem_addr_o < 32'h7C0, "R5 no data read for zero length", mem_addr_o, 32'h7C0);
                    chk(int'(mem_burst_o) == ((region_end(mem_addr_o) - int'(mem_addr_o)) / 4 > 16 ? 16 :
                        (region_end(mem_addr_o) - int'(mem_addr_o)) / 4), "R3 burst length",
                        32'(mem_burst_o), 32'd16);
                    if (is_pix(mem_addr_o))
                        chk(int'(mem_burst_o) <= FDEPTH - (delivered - popped), "R7 FIFO room",
                            32'(mem_burst_o), 32'(FDEPTH - (delivered - popped)));
                end
                if (mem_addr_o == 32'h100) a_fetch++;
                mem_gnt_i = 1'b1; baddr = mem_addr_o; blen = mem_burst_o;
            end
        end
    end

    // Pixel monitor: compares popped words with the scoreboard.
    logic [31:0] prev_data = '0;
    bit a_id_done = 1'b0;
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (pix_valid_o) popped++;
            if (sb_on) begin
                if (pix_valid_o) begin
                    if (qpix.size() != 0) begin
                        logic [31:0] e;
                        e = qpix.pop_front();
                        chk(pix_data_o == e, "R9/R2/R4 pixel order", pix_data_o, e);
                        if (e == 32'hC0DE0400 && !a_id_done) begin
                            a_id_done = 1'b1;
                            chk(frame_id_o == 32'hA1, "R8 frame tag", frame_id_o, 32'hA1);
                        end
                    end
                end else if (pix_ready_i) begin
                    chk(pix_data_o == (protect_i ? prev_data : 32'h0), "R10 underrun data",
                        pix_data_o, protect_i ? prev_data : 32'h0);
                    chk(underrun_o == 1'b1, "R10 underrun flag", 32'(underrun_o), 32'd1);
                end
            end
            prev_data = pix_data_o;
        end
    end

    // Palette monitor: samples the write just before the committing edge.
    always @(negedge clk) begin
        #4;
        if (rst_n && sb_on && pal_we_o && qpal.size() != 0) begin
            logic [39:0] e;
            e = qpal.pop_front();
            chk({pal_addr_o, pal_wdata_o} == e, "R2 palette write", pal_wdata_o, e[31:0]);
            chk(frame_id_o == 32'hB0, "R8 tag during palette", frame_id_o, 32'hB0);
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 512; i++) mem_arr[i] = 32'hC0DE0000 | (i * 4);
        // A: self-linked 40-word frame
        mem_arr[32'h100 >> 2] = 32'h100; mem_arr[(32'h100 >> 2) + 1] = 32'h400;
        mem_arr[(32'h100 >> 2) + 2] = 32'hA1; mem_arr[(32'h100 >> 2) + 3] = 32'd40;
        // Z: zero-length, links to palette descriptor
        mem_arr[32'h280 >> 2] = 32'h200; mem_arr[(32'h280 >> 2) + 1] = 32'h7C0;
        mem_arr[(32'h280 >> 2) + 2] = 32'hC0; mem_arr[(32'h280 >> 2) + 3] = 32'd0;
        // P: 8 palette words, links to F
        mem_arr[32'h200 >> 2] = 32'h180; mem_arr[(32'h200 >> 2) + 1] = 32'h600;
        mem_arr[(32'h200 >> 2) + 2] = 32'hB0; mem_arr[(32'h200 >> 2) + 3] = (32'd1 << 28) | 32'd8;
        // F: 20-word frame, links back to P
        mem_arr[32'h180 >> 2] = 32'h200; mem_arr[(32'h180 >> 2) + 1] = 32'h700;
        mem_arr[(32'h180 >> 2) + 2] = 32'hB1; mem_arr[(32'h180 >> 2) + 3] = 32'd20;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(underrun_o == 1'b0, "R12 underrun", 32'(underrun_o), 32'd0);
        chk(pix_valid_o == 1'b0, "R12 valid", 32'(pix_valid_o), 32'd0);
        chk(mem_req_o == 1'b0, "R12 request", 32'(mem_req_o), 32'd0);
        chk(pal_we_o == 1'b0, "R12 palette write", 32'(pal_we_o), 32'd0);
        chk(frame_id_o == 32'h0, "R12 frame tag", frame_id_o, 32'h0);
        chk(pix_data_o == 32'h0, "R12 pixel data", pix_data_o, 32'h0);

        // Underrun with empty FIFO, then clear, then clear against a new underrun
        pix_ready_i = 1'b1;
        @(negedge clk);
        chk(underrun_o == 1'b1, "R10 flag on empty pull", 32'(underrun_o), 32'd1);
        chk(pix_valid_o == 1'b0 && pix_data_o == 32'h0, "R10 held output", pix_data_o, 32'h0);
        pix_ready_i = 1'b0; underrun_clr_i = 1'b1;
        @(negedge clk);
        chk(underrun_o == 1'b0, "R11 clear", 32'(underrun_o), 32'd0);
        pix_ready_i = 1'b1;
        @(negedge clk);
        chk(underrun_o == 1'b1, "R11 set beats clear", 32'(underrun_o), 32'd1);
        pix_ready_i = 1'b0;
        @(negedge clk);
        chk(underrun_o == 1'b0, "R11 clear again", 32'(underrun_o), 32'd0);
        underrun_clr_i = 1'b0;
        chk(mem_req_o == 1'b0, "R6 idle until start", 32'(mem_req_o), 32'd0);

        // Scoreboard: three passes of A, then F twice; palette P twice
        for (int p = 0; p < 3; p++)
            for (int i = 0; i < 40; i++) qpix.push_back(32'hC0DE0400 + 32'(i * 4));
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 20; i++) qpix.push_back(32'hC0DE0700 + 32'(i * 4));
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 8; i++) qpal.push_back({8'(i), 32'hC0DE0600 + 32'(i * 4)});
        sb_on = 1'b1;

        // R6: start while idle, unaligned address forced to 0x100
        start_addr_i = 32'h101; start_wr_i = 1'b1;
        @(negedge clk);
        start_wr_i = 1'b0;
        pix_ready_i = 1'b1;

        // R6: start while running, during A's third pass
        while (a_fetch < 3) @(negedge clk);
        start_addr_i = 32'h281; start_wr_i = 1'b1;
        @(negedge clk);
        start_wr_i = 1'b0;

        while (qpix.size() > 40) @(negedge clk);
        protect_i = 1'b0;
        while (qpix.size() != 0 || qpal.size() != 0) @(negedge clk);

        // R7: stop pulling; the sequencer must stall on FIFO room
        pix_ready_i = 1'b0;
        repeat (300) @(negedge clk);
        chk(mem_req_o == 1'b0, "R7 stalled on full FIFO", 32'(mem_req_o), 32'd0);
        chk(frame_id_o == 32'hB1, "R8/R4 stalled in frame descriptor", frame_id_o, 32'hB1);
        chk(underrun_o == 1'b1, "R10 flag stays sticky", 32'(underrun_o), 32'd1);
        sb_on = 1'b0;
        finish_run();
    end

endmodule